// File: doc/BRIEF.md
# Folded cube-connected cycles neighbour generator

This block computes adjacency in a folded cube-connected cycles network of dimension `N_DIM`. A node is named by a pair made of an `N_DIM`-bit cube address and a ring position from 0 up to `N_DIM` inclusive, so each ring holds `N_DIM+1` nodes. Every node has three links: forward along its ring, backward along its ring, and one cube link. On positions below `N_DIM` the cube link flips the single address bit whose index equals the position. On position `N_DIM` it is the folded link, which inverts the whole address.

A router or a traffic generator presents a label and a 2-bit link selector. The block returns the label at the far end of that link. It also raises an error flag when the selector is the reserved code or the position lies outside the ring. In either error case the label passes through unchanged. With `REGISTERED=1` (the default), one output register sits behind the logic, and a valid bit travels with the data, giving one cycle of latency. With `REGISTERED=0` the outputs follow the inputs combinationally.

Top module: `fccc_neighbor_gen`

## Requirements
- R1: Selector code 0 (forward) on a position p below `N_DIM` yields the same address with position p+1.
- R2: Selector code 0 on position `N_DIM` yields the same address with position 0.
- R3: Selector code 1 (backward) yields the same address with position p-1, and position 0 yields position `N_DIM`.
- R4: Selector code 2 (cube) on a position p below `N_DIM` yields the same position and an address that differs from the input only in bit p.
- R5: Selector code 2 on position `N_DIM` yields the same position and the bitwise inverse of the input address.
- R6: Selector code 3 is reserved. It raises `out_err` and returns the input address and position unchanged.
- R7: An input position above `N_DIM` raises `out_err` and returns the input address and position unchanged, whatever the selector.
- R8: With `REGISTERED=1`, `out_valid` is 0 during reset and, after reset, equals `in_valid` of the previous cycle. The result shown belongs to the input of that cycle.
- R9: Following the cube link twice from any valid label returns the original label.
- R10: `out_err` is 0 whenever the selector is 0, 1 or 2 and the position is at most `N_DIM`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input label is present |
| in_addr | input | N_DIM | Cube address of the source node |
| in_pos | input | $clog2(N_DIM+1) | Ring position of the source node |
| in_port | input | 2 | Link selector: 0 forward, 1 backward, 2 cube, 3 reserved |
| out_valid | output | 1 | Output label is present |
| out_addr | output | N_DIM | Cube address of the neighbour |
| out_pos | output | $clog2(N_DIM+1) | Ring position of the neighbour |
| out_err | output | 1 | Reserved selector or out-of-range position |

## Verification
The bench sweeps every address, every encodable position and every selector code, so both ring wrap points and the folded link at position `N_DIM` are always hit. A design that forgot the wrap would emit position `N_DIM+1`. One that treated the last position as an ordinary dimension would flip a non-existent bit and leave the address unchanged. Encodable positions above `N_DIM` are checked so that a missing range test shows up as a spurious neighbour with no error. Pairs of cube hops fed back from the outputs catch any asymmetry between the folded and unfolded links. Idle gaps and the reset window catch a valid bit that sticks or leads its data.

// File: rtl/fccc_pkg.sv
package fccc_pkg;

    typedef enum logic [1:0] {
        PORT_NEXT = 2'd0,
        PORT_PREV = 2'd1,
        PORT_CUBE = 2'd2,
        PORT_RSVD = 2'd3
    } fccc_port_e;

endpackage

// File: rtl/fccc_ring_step.sv
module fccc_ring_step #(
    parameter int N_DIM    = 4,
    parameter bit STEP_BACK = 1'b0
) (
    input  logic [$clog2(N_DIM+1)-1:0] pos_i,
    output logic [$clog2(N_DIM+1)-1:0] pos_o
);
    localparam int POS_W = $clog2(N_DIM+1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_DIM);
    localparam logic [POS_W-1:0] ONE_POS  = POS_W'(1);

    generate
        if (STEP_BACK) begin : g_back
            always_comb begin
                if (pos_i == '0) pos_o = LAST_POS;
                else             pos_o = pos_i - ONE_POS;
            end
        end else begin : g_fwd
            always_comb begin
                if (pos_i == LAST_POS) pos_o = '0;
                else                   pos_o = pos_i + ONE_POS;
            end
        end
    endgenerate
endmodule

// File: rtl/fccc_cube_link.sv
module fccc_cube_link #(
    parameter int N_DIM = 4
) (
    input  logic [N_DIM-1:0]           addr_i,
    input  logic [$clog2(N_DIM+1)-1:0] pos_i,
    output logic [N_DIM-1:0]           addr_o
);
    localparam int POS_W = $clog2(N_DIM+1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_DIM);

    logic fold;
    assign fold = (pos_i == LAST_POS);

    for (genvar b = 0; b < N_DIM; b++) begin : g_bit
        assign addr_o[b] = addr_i[b] ^ (fold || (pos_i == POS_W'(b)));
    end
endmodule

// File: rtl/fccc_label_check.sv
module fccc_label_check
    import fccc_pkg::*;
#(
    parameter int N_DIM = 4
) (
    input  logic [$clog2(N_DIM+1)-1:0] pos_i,
    input  fccc_port_e                 port_i,
    output logic                       err_o
);
    localparam int POS_W = $clog2(N_DIM+1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_DIM);

    assign err_o = (port_i == PORT_RSVD) || (pos_i > LAST_POS);
endmodule

// File: rtl/fccc_neighbor_gen.sv
module fccc_neighbor_gen
    import fccc_pkg::*;
#(
    parameter int N_DIM      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [N_DIM-1:0]           in_addr,
    input  logic [$clog2(N_DIM+1)-1:0] in_pos,
    input  logic [1:0]                 in_port,
    output logic                       out_valid,
    output logic [N_DIM-1:0]           out_addr,
    output logic [$clog2(N_DIM+1)-1:0] out_pos,
    output logic                       out_err
);
    localparam int POS_W = $clog2(N_DIM+1);

    fccc_port_e             sel;
    logic [POS_W-1:0]       pos_fwd;
    logic [POS_W-1:0]       pos_back;
    logic [N_DIM-1:0]       addr_cube;
    logic                   bad_label;
    logic [N_DIM-1:0]       nxt_addr;
    logic [POS_W-1:0]       nxt_pos;
    logic                   nxt_err;

    assign sel = fccc_port_e'(in_port);

    fccc_ring_step #(.N_DIM(N_DIM), .STEP_BACK(1'b0)) fwd_i (
        .pos_i (in_pos),
        .pos_o (pos_fwd)
    );

    fccc_ring_step #(.N_DIM(N_DIM), .STEP_BACK(1'b1)) back_i (
        .pos_i (in_pos),
        .pos_o (pos_back)
    );

    fccc_cube_link #(.N_DIM(N_DIM)) cube_i (
        .addr_i (in_addr),
        .pos_i  (in_pos),
        .addr_o (addr_cube)
    );

    fccc_label_check #(.N_DIM(N_DIM)) check_i (
        .pos_i  (in_pos),
        .port_i (sel),
        .err_o  (bad_label)
    );

    always_comb begin
        nxt_addr = in_addr;
        nxt_pos  = in_pos;
        nxt_err  = bad_label;
        if (!bad_label) begin
            unique case (sel)
                PORT_NEXT: nxt_pos  = pos_fwd;
                PORT_PREV: nxt_pos  = pos_back;
                PORT_CUBE: nxt_addr = addr_cube;
                default: ;
            endcase
        end
    end

    generate
        if (REGISTERED) begin : g_reg
            logic             valid_q;
            logic [N_DIM-1:0] addr_q;
            logic [POS_W-1:0] pos_q;
            logic             err_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    addr_q  <= '0;
                    pos_q   <= '0;
                    err_q   <= 1'b0;
                end else begin
                    valid_q <= in_valid;
                    if (in_valid) begin
                        addr_q <= nxt_addr;
                        pos_q  <= nxt_pos;
                        err_q  <= nxt_err;
                    end
                end
            end

            assign out_valid = valid_q;
            assign out_addr  = addr_q;
            assign out_pos   = pos_q;
            assign out_err   = err_q;
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_addr  = nxt_addr;
            assign out_pos   = nxt_pos;
            assign out_err   = nxt_err;
        end
    endgenerate
endmodule

// File: rtl/fccc_neighbor_chk.sv
module fccc_neighbor_chk #(
    parameter int N_DIM      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [N_DIM-1:0]           in_addr,
    input logic [$clog2(N_DIM+1)-1:0] in_pos,
    input logic [1:0]                 in_port,
    input logic                       out_valid,
    input logic [N_DIM-1:0]           out_addr,
    input logic [$clog2(N_DIM+1)-1:0] out_pos,
    input logic                       out_err
);
    localparam int POS_W = $clog2(N_DIM+1);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_DIM);

    generate
        if (REGISTERED) begin : g_seq
            a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            a_r8_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            a_r2_fwd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_port == 2'd0 && in_pos == LAST_POS)
                |=> (out_pos == '0 && !out_err));
            a_r3_back_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_port == 2'd1 && in_pos == '0)
                |=> (out_pos == LAST_POS && !out_err));
            a_r4_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_port == 2'd2 && in_pos < LAST_POS)
                |=> ($countones(out_addr ^ $past(in_addr)) == 1
                     && out_pos == $past(in_pos)));
            a_r5_fold: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_port == 2'd2 && in_pos == LAST_POS)
                |=> (out_addr == ~$past(in_addr) && !out_err));
            a_r6_rsvd_port: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_port == 2'd3)
                |=> (out_err && out_addr == $past(in_addr) && out_pos == $past(in_pos)));
            a_r7_bad_pos: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_pos > LAST_POS)
                |=> (out_err && out_addr == $past(in_addr) && out_pos == $past(in_pos)));
        end else begin : g_comb
            a_r2_fwd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                (in_port == 2'd0 && in_pos == LAST_POS) |-> (out_pos == '0 && !out_err));
            a_r5_fold: assert property (@(posedge clk) disable iff (!rst_n)
                (in_port == 2'd2 && in_pos == LAST_POS) |-> (out_addr == ~in_addr));
            a_r6_rsvd_port: assert property (@(posedge clk) disable iff (!rst_n)
                (in_port == 2'd3) |-> (out_err && out_addr == in_addr && out_pos == in_pos));
            a_r7_bad_pos: assert property (@(posedge clk) disable iff (!rst_n)
                (in_pos > LAST_POS) |-> (out_err && out_addr == in_addr));
        end
    endgenerate
endmodule

bind fccc_neighbor_gen fccc_neighbor_chk #(
    .N_DIM      (N_DIM),
    .REGISTERED (REGISTERED)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_addr   (in_addr),
    .in_pos    (in_pos),
    .in_port   (in_port),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_pos   (out_pos),
    .out_err   (out_err)
);

// File: tb/fccc_neighbor_gen_tb.sv
module fccc_neighbor_gen_tb_top;
    localparam int N  = 4;
    localparam int PW = $clog2(N+1);

    typedef struct {
        logic [N-1:0]  addr;
        logic [PW-1:0] pos;
        logic          err;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [N-1:0]  in_addr;
    logic [PW-1:0] in_pos;
    logic [1:0]    in_port;
    logic          out_valid;
    logic [N-1:0]  out_addr;
    logic [PW-1:0] out_pos;
    logic          out_err;

    int checks   = 0;
    int failures = 0;
    exp_t sb_q[$];
    logic [N-1:0]  last_addr;
    logic [PW-1:0] last_pos;

    always #4 clk = ~clk;

    fccc_neighbor_gen #(.N_DIM(N), .REGISTERED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_pos(in_pos), .in_port(in_port), .out_valid(out_valid),
        .out_addr(out_addr), .out_pos(out_pos), .out_err(out_err)
    );

    function automatic exp_t model(input logic [N-1:0] a, input logic [PW-1:0] p,
                                   input logic [1:0] s, input string tag);
        exp_t e;
        e.addr = a; e.pos = p; e.err = 1'b0; e.tag = tag;
        if (s == 2'd3 || int'(p) > N) begin
            e.err = 1'b1;
        end else if (s == 2'd0) begin
            e.pos = (int'(p) == N) ? '0 : PW'(int'(p) + 1);
        end else if (s == 2'd1) begin
            e.pos = (p == '0) ? PW'(N) : PW'(int'(p) - 1);
        end else if (int'(p) == N) begin
            e.addr = ~a;
        end else begin
            e.addr = a ^ (N'(1) << p);
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [PW-1:0] p, input logic [1:0] s);
        if (int'(p) > N)          return "R7";
        if (s == 2'd3)            return "R6";
        if (s == 2'd0)            return (int'(p) == N) ? "R2/R10" : "R1/R10";
        if (s == 2'd1)            return "R3/R10";
        return (int'(p) == N) ? "R5/R10" : "R4/R10";
    endfunction

    task automatic push_drive(input logic [N-1:0] a, input logic [PW-1:0] p,
                              input logic [1:0] s, input exp_t e);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_pos = p; in_port = s;
        sb_q.push_back(e);
    endtask

    task automatic send(input logic [N-1:0] a, input logic [PW-1:0] p, input logic [1:0] s);
        push_drive(a, p, s, model(a, p, s, tag_of(p, s)));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: one item per output beat
    always @(posedge clk) begin
        #2;
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R8", "output with empty queue", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (out_addr !== e.addr || out_pos !== e.pos || out_err !== e.err) begin
                    failures++;
                    $display("FAIL %s actual=(%0h,%0d,err%0b) expected=(%0h,%0d,err%0b)",
                             e.tag, out_addr, out_pos, out_err, e.addr, e.pos, e.err);
                end
                last_addr = out_addr;
                last_pos  = out_pos;
            end
        end
    end

    task automatic cube_twice(input logic [N-1:0] a, input logic [PW-1:0] p);
        exp_t back;
        send(a, p, 2'd2);
        idle();
        back.addr = a; back.pos = p; back.err = 1'b0; back.tag = "R9";
        push_drive(last_addr, last_pos, 2'd2, back);
        idle();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_pos = '0; in_port = '0;
        repeat (3) @(posedge clk);
        #2;
        check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        check(out_valid == 1'b0, "R8", "out_valid idle after reset", int'(out_valid), 0);

        // Named corner cases first
        send(4'hA, 3'd4, 2'd0);  // R2 wrap forward
        send(4'h3, 3'd0, 2'd1);  // R3 wrap backward
        send(4'h5, 3'd4, 2'd2);  // R5 folded link
        send(4'h0, 3'd3, 2'd2);  // R4 top ordinary bit
        send(4'h9, 3'd2, 2'd3);  // R6 reserved selector
        send(4'h7, 3'd6, 2'd0);  // R7 out-of-range position
        idle();
        @(posedge clk); #2;
        check(out_valid == 1'b0, "R8", "out_valid after gap", int'(out_valid), 0);

        // Exhaustive back-to-back sweep
        for (int a = 0; a < (1 << N); a++)
            for (int p = 0; p < (1 << PW); p++)
                for (int s = 0; s < 4; s++)
                    send(N'(a), PW'(p), 2'(s));
        idle();

        // R9: two cube hops return home, fed back from the outputs
        for (int a = 0; a < (1 << N); a += 3)
            for (int p = 0; p <= N; p++)
                cube_twice(N'(a), PW'(p));

        repeat (4) idle();
        check(sb_q.size() == 0, "R8", "items left in queue", sb_q.size(), 0);
        finish_run();
    end
endmodule